// File: doc/BRIEF.md
# Standby Bus Wake-Up Filter

This block decides, while a bus transceiver is in its low-power standby state, whether activity on the bus is a genuine request to wake the node. A low-power comparator reports the bus level as a single digital input, where 1 means dominant. The block passes a wake request to the host controller through an active-low receive line. A dominant period counts as a wake only if it follows a recessive level and lasts longer than a minimum wake time. A second limit removes the request if the bus then stays dominant for too long. This keeps a bus that is shorted or clamped dominant from holding the controller awake forever.

The request only informs the controller. It never changes the operating state by itself. The state changes when the controller drops the standby input. Outside standby, or while a supply undervoltage is flagged, the filter is held in its cleared state and its output rests high. Both limits are parameters counted in clock cycles. The time-out limit must be larger than the wake limit.

Top module: `bus_wake_filter`

## Requirements
- R1: After reset the wake output `rxd_n_o` is high (no request). It stays high until a wake qualifies.
- R2: Suppose a cycle samples `bus_dom_i` = 0 and is followed by WAKE_CYC+1 consecutive cycles that sample `bus_dom_i` = 1. Then `rxd_n_o` is low in the cycle after the last of those samples.
- R3: A dominant run of WAKE_CYC samples or fewer raises no request. The next run is counted from zero again after the intervening recessive sample.
- R4: A bus that is already dominant when standby starts raises no request, however long it lasts, until at least one recessive sample has been taken.
- R5: Once armed by a recessive sample, a dominant run of TIMEOUT_CYC+1 consecutive samples returns `rxd_n_o` high in the cycle after the last of them.
- R6: After a time-out, continued dominance raises nothing. A new request needs a recessive sample followed by a qualifying dominant run.
- R7: A raised request stays low when the bus returns to recessive and through later dominant runs. A recessive sample restarts the time-out count, so two runs of TIMEOUT_CYC dominant samples split by one recessive sample do not clear it.
- R8: A cycle that samples `standby_i` = 0 or `uv_i` = 1 clears the request and the arming. `rxd_n_o` is high in the next cycle, and a later wake needs a fresh recessive sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | 1 while the transceiver is in standby |
| uv_i | input | 1 | 1 while a supply undervoltage is flagged |
| bus_dom_i | input | 1 | Wake comparator output, 1 = dominant bus |
| rxd_n_o | output | 1 | Wake request, active low |

## Verification
A wrong arming flag shows up in two ways: a request appears on a dominant bus that was never seen recessive, or a valid wake is missed. Either one is visible at `rxd_n_o` within WAKE_CYC+1 cycles of the dominant edge. A dominant-run counter that miscounts, or one that fails to clear on a recessive sample, moves the falling edge of `rxd_n_o` or the time-out rise by at least one cycle. A model that compares every clock catches that at once. A request latch that leaks through a mode exit shows within one cycle of `standby_i` falling or `uv_i` rising.

// File: rtl/wake_filt_pkg.sv
package wake_filt_pkg;

  function automatic int unsigned cnt_width(input int unsigned tmo);
    return (tmo < 2) ? 1 : $clog2(tmo + 1);
  endfunction

  // True when the run length seen so far equals the limit, so the sample
  // now being taken is the first one beyond it.
  function automatic logic beyond_limit(input int unsigned run, input int unsigned lim);
    return run == lim;
  endfunction

endpackage

// File: rtl/wake_arm_track.sv
module wake_arm_track (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bus_dom,
  input  logic tmo_hit,
  output logic armed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed <= 1'b0;
    else if (clr)     armed <= 1'b0;
    else if (tmo_hit) armed <= 1'b0;
    else if (!bus_dom) armed <= 1'b1;
  end

  assert_arm_needs_recessive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(!bus_dom));
  assert_tmo_disarms_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> !armed);
endmodule

// File: rtl/wake_dom_count.sv
module wake_dom_count
  import wake_filt_pkg::*;
#(
  parameter int unsigned WAKE_CYC    = 100,
  parameter int unsigned TIMEOUT_CYC = 125000,
  parameter int unsigned CW          = 17
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bus_dom,
  input  logic armed,
  output logic wake_hit,
  output logic tmo_hit
);
  logic [CW-1:0] run_q;
  logic          counting;

  assign counting = armed && bus_dom;
  assign wake_hit = counting && beyond_limit(int'(run_q), WAKE_CYC);
  assign tmo_hit  = counting && beyond_limit(int'(run_q), TIMEOUT_CYC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        run_q <= '0;
    else if (clr || !bus_dom || tmo_hit) run_q <= '0;
    else if (counting)                 run_q <= run_q + 1'b1;
  end

  assert_run_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(run_q) <= TIMEOUT_CYC);
  assert_recessive_restarts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_dom |=> run_q == '0);
  assert_hits_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wake_hit && tmo_hit));
endmodule

// File: rtl/wake_req_hold.sv
module wake_req_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic wake_hit,
  input  logic tmo_hit,
  output logic req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        req <= 1'b0;
    else if (clr)      req <= 1'b0;
    else if (tmo_hit)  req <= 1'b0;
    else if (wake_hit) req <= 1'b1;
  end

  assert_tmo_drops_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> !req);
  assert_exit_drops_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !req);
endmodule

// File: rtl/bus_wake_filter.sv
module bus_wake_filter
  import wake_filt_pkg::*;
#(
  parameter int unsigned WAKE_CYC    = 100,
  parameter int unsigned TIMEOUT_CYC = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic standby_i,
  input  logic uv_i,
  input  logic bus_dom_i,
  output logic rxd_n_o
);
  localparam int unsigned CW = cnt_width(TIMEOUT_CYC);

  logic clr, armed, wake_hit, tmo_hit, req;

  assign clr = !standby_i || uv_i;

  wake_arm_track u_arm (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bus_dom(bus_dom_i),
    .tmo_hit(tmo_hit), .armed(armed)
  );

  wake_dom_count #(.WAKE_CYC(WAKE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC), .CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bus_dom(bus_dom_i),
    .armed(armed), .wake_hit(wake_hit), .tmo_hit(tmo_hit)
  );

  wake_req_hold u_req (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wake_hit(wake_hit),
    .tmo_hit(tmo_hit), .req(req)
  );

  assign rxd_n_o = !req;

  assert_wake_on_dominant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rxd_n_o) |-> $past(bus_dom_i) && $past(armed));
  assert_inactive_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> rxd_n_o);
  assert_no_wake_unarmed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rxd_n_o && !armed) |=> rxd_n_o);
endmodule

// File: tb/tb_bus_wake_filter.sv
module tb_bus_wake_filter;
  localparam int unsigned WAKE = 6;
  localparam int unsigned TMO  = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic standby_i = 1'b0, uv_i = 1'b0, bus_dom_i = 1'b0;
  logic rxd_n_o;

  int tests = 0, fails = 0;
  bit done = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  bus_wake_filter #(.WAKE_CYC(WAKE), .TIMEOUT_CYC(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .standby_i(standby_i), .uv_i(uv_i),
    .bus_dom_i(bus_dom_i), .rxd_n_o(rxd_n_o)
  );

  // Behavioural reference: run length as an integer, two flags.
  bit m_seen_rec, m_req;
  int m_run;
  always @(posedge clk) begin
    if (!rst_n || !standby_i || uv_i) begin
      m_seen_rec = 0; m_req = 0; m_run = 0;
    end else if (!bus_dom_i) begin
      m_seen_rec = 1; m_run = 0;
    end else if (m_seen_rec) begin
      m_run++;
      if (m_run > TMO) begin m_req = 0; m_seen_rec = 0; m_run = 0; end
      else if (m_run > WAKE) m_req = 1;
    end
  end

  task automatic chk(input logic exp, input string what);
    tests++;
    if (rxd_n_o !== exp) begin
      fails++;
      $display("FAIL %s %s: rxd_n_o=%0b expected=%0b", tag, what, rxd_n_o, exp);
    end
  endtask

  task automatic cyc(input logic dom, input logic stb = 1'b1, input logic uv = 1'b0);
    bus_dom_i = dom; standby_i = stb; uv_i = uv;
    @(posedge clk); #2;
    chk(!m_req, "model");
  endtask

  task automatic run(input logic dom, input int n);
    for (int i = 0; i < n; i++) cyc(dom);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2; chk(1'b1, "reset");            // R1
    rst_n = 1'b1;
    cyc(1'b0, 1'b0); cyc(1'b0, 1'b0);
    tag = "R1"; chk(1'b1, "idle");

    tag = "R4"; cyc(1'b1, 1'b0);
    run(1'b1, 40); chk(1'b1, "pre-dominant ignored");

    tag = "R3"; run(1'b0, 3); run(1'b1, WAKE); chk(1'b1, "pulse of WAKE");
    for (int k = 0; k < 8; k++) begin run(1'b0, 1); run(1'b1, 3); end
    chk(1'b1, "short pulses");

    tag = "R2"; run(1'b0, 2); run(1'b1, WAKE); chk(1'b1, "one short");
    run(1'b1, 1); chk(1'b0, "wake raised");

    tag = "R7"; run(1'b0, 5); chk(1'b0, "held on recessive");
    run(1'b1, 10); run(1'b0, 1); chk(1'b0, "held over dominant");

    tag = "R5"; run(1'b1, TMO); chk(1'b0, "at limit");
    run(1'b1, 1); chk(1'b1, "timed out");

    tag = "R6"; run(1'b1, 20); chk(1'b1, "stays clear");
    run(1'b0, 1); run(1'b1, WAKE + 1); chk(1'b0, "fresh wake");

    tag = "R7"; run(1'b0, 1); run(1'b1, TMO); run(1'b0, 1); run(1'b1, TMO);
    chk(1'b0, "split runs");

    tag = "R8"; cyc(1'b1, 1'b0); chk(1'b1, "standby exit");
    run(1'b1, 10); chk(1'b1, "re-entry needs recessive");
    run(1'b0, 1); run(1'b1, WAKE + 1); chk(1'b0, "rewake");
    cyc(1'b1, 1'b1, 1'b1); chk(1'b1, "undervoltage");
    run(1'b1, WAKE + 1); chk(1'b1, "disarmed by uv");
    run(1'b0, 1); run(1'b1, WAKE + 1); chk(1'b0, "after uv");
    run(1'b0, 4);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run hung");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule